// File: doc/BRIEF.md
# Blanking-Gated Video Field Capture Controller

This block decides when a video-input capture path may start writing a field into memory. Software programs a destination base word address and a field length in words, then writes a one to the activation bit of the control register. The request is honoured only while the incoming video is in vertical blanking. The block then waits for the next field start. It moves exactly the programmed number of pixel words through a small input FIFO to a simple memory write port and raises an end-of-transfer flag. A request made while a field is active starts nothing and raises an error flag instead.

A decimation mode keeps only every other field. A field that is skipped while armed is still pulled through the FIFO and thrown away. The FIFO is therefore empty before the next kept field, and no word of the skipped field reaches the next buffer. Four sticky event flags (vsync, field start, end of transfer, start error) are cleared by writing ones. The flags are masked onto one interrupt line.

Register map on `cfg_addr`:
- 0 is control. Bit 27 is activate and writes as one. Bit 0 enables decimation. Bits 7:4 are the interrupt enables.
- 1 is the base word address.
- 2 is the field size in words, which must be 1 or more.
- 3 is the flag clear: ones in bits 3:0 clear flags.

Flag bits are 0 for vsync, 1 for field start, 2 for end of transfer and 3 for start error.

Top module: `vcap_gate`

## Requirements
- R1: An activation (control write with bit 27 set) made while `vid_active` is low and the block is idle is accepted. `cap_busy` reads 1 from the next cycle.
- R2: An activation made while `vid_active` is high starts no transfer and sets flag bit 3. It writes nothing to memory in that field.
- R3: The base address and size are sampled when the activation is accepted. Later writes to registers 1 and 2 do not affect the running transfer.
- R4: A kept field writes word i of the field to address base+i, in arrival order. It writes exactly `size` words, and extra pixel words in the field are ignored.
- R5: Flag bit 2 is set when the last word of the field is written, and `cap_busy` returns to 0 at the same time. The next field needs a new activation.
- R6: A rising `vid_vsync` sets flag bit 0, and a rising `vid_active` sets flag bit 1.
- R7: Flags stay set until cleared by a one written to the matching bit of register 3. `irq` is the OR of the flags ANDed with control bits 7:4.
- R8: With decimation on (control bit 0), the keep/drop phase toggles at every field start. A field is kept when the phase says keep. Turning decimation off forces keep, so the first field after enabling it from that state is kept.
- R9: A dropped field writes nothing to memory and leaves `cap_busy` at 1. The next kept field goes to the armed base and holds only its own words.
- R10: While `mem_ready` is low, `mem_wr`, `mem_addr` and `mem_data` hold. No word is lost or reordered.
- R11: Without an activation, a field writes nothing to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| vid_vsync | input | 1 | Vertical sync from video input |
| vid_active | input | 1 | High during the active field, low in blanking |
| pix_valid | input | 1 | Pixel word present |
| pix_data | input | DATA_W | Pixel word |
| mem_ready | input | 1 | Memory accepts the current write |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory word address |
| mem_data | output | DATA_W | Memory write data |
| cap_busy | output | 1 | Activation bit: armed or transferring |
| irq_flags | output | 4 | Sticky event flags |
| irq | output | 1 | Masked interrupt line |

## Verification
The assertions check five rules on every cycle. Busy can only rise out of blanking. A rejected activation never arms the block. No write appears while a field is being dropped or while idle. A stalled write holds its address and data. The FIFO is never pushed while full.

Some behaviour is only visible across whole fields, so the bench scenarios have to show it:
- the exact address and data sequence of a kept field, and the cut-off of extra words;
- that register changes after acceptance are ignored;
- the keep/drop rhythm of decimation, and that no stale word leaks into the following buffer;
- the sticky-flag, clear and mask behaviour.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_CAP, ST_DROP} cap_state_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_BASE = 2'd1;
  localparam logic [1:0] REG_SIZE = 2'd2;
  localparam logic [1:0] REG_CLR  = 2'd3;

  localparam int ACT_BIT  = 27;
  localparam int DEC_BIT  = 0;
  localparam int MASK_LSB = 4;
  localparam int NFLAG    = 4;

  localparam int FLG_VS  = 0;
  localparam int FLG_FS  = 1;
  localparam int FLG_EOT = 2;
  localparam int FLG_ERR = 3;

  // address of the idx-th word of a field
  function automatic logic [31:0] word_addr(input logic [31:0] base, input logic [31:0] idx);
    return base + idx;
  endfunction

  // true when idx is the final word index of a field of len words
  function automatic logic is_last(input logic [31:0] idx, input logic [31:0] len);
    return (idx + 32'd1) == len;
  endfunction
endpackage

// File: rtl/vcap_fifo.sv
module vcap_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] slot_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == (PW+1)'(DEPTH));
  assign dout  = slot_q[rp_q];

  always_ff @(posedge clk) begin
    if (push) slot_q[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/vcap_irq.sv
module vcap_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic [N-1:0] mask,
  output logic [N-1:0] flags,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_vec) | set_vec;
  end

  assign irq = |(flags & mask);
endmodule

// File: rtl/vcap_seq.sv
module vcap_seq
  import vcap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_req,
  input  logic              decimate,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [CNT_W-1:0]  size_in,
  input  logic              vid_active,
  input  logic              pix_valid,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  input  logic              mem_ready,
  output logic              busy,
  output logic              start_err,
  output logic              field_start,
  output logic              eot,
  output logic              dropping,
  output logic              push,
  output logic              pop,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr
);
  cap_state_e        st_q;
  logic              act_prev_q, keep_q;
  logic [ADDR_W-1:0] cur_base_q;
  logic [CNT_W-1:0]  cur_size_q, in_cnt_q, out_cnt_q;
  logic              accept, cap_go, drop_go, in_cap, in_drop;

  assign field_start = vid_active & ~act_prev_q;
  assign accept      = act_req & (st_q == ST_IDLE) & ~vid_active;
  assign start_err   = act_req & vid_active;
  assign cap_go      = (st_q == ST_ARMED) & field_start & keep_q;
  assign drop_go     = (st_q == ST_ARMED) & field_start & ~keep_q;
  assign in_cap      = (st_q == ST_CAP) | cap_go;
  assign in_drop     = (st_q == ST_DROP) | drop_go;

  assign push     = vid_active & pix_valid & ~fifo_full &
                    ((in_cap & (in_cnt_q < cur_size_q)) | in_drop);
  assign mem_wr   = (st_q == ST_CAP) & ~fifo_empty;
  assign pop      = ~fifo_empty & (((st_q == ST_CAP) & mem_ready) | (st_q == ST_DROP));
  assign eot      = (st_q == ST_CAP) & pop & is_last(32'(out_cnt_q), 32'(cur_size_q));
  assign dropping = (st_q == ST_DROP);
  assign busy     = (st_q != ST_IDLE);
  assign mem_addr = ADDR_W'(word_addr(32'(cur_base_q), 32'(out_cnt_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      act_prev_q <= 1'b0;
      keep_q     <= 1'b1;
      cur_base_q <= '0;
      cur_size_q <= '0;
      in_cnt_q   <= '0;
      out_cnt_q  <= '0;
    end else begin
      act_prev_q <= vid_active;
      if (field_start)   keep_q <= decimate ? ~keep_q : 1'b1;
      else if (!decimate) keep_q <= 1'b1;

      if (push && in_cap)                 in_cnt_q  <= in_cnt_q + 1'b1;
      if (pop && (st_q == ST_CAP))        out_cnt_q <= out_cnt_q + 1'b1;

      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q       <= ST_ARMED;
          cur_base_q <= base_in;
          cur_size_q <= size_in;
          in_cnt_q   <= '0;
          out_cnt_q  <= '0;
        end
        ST_ARMED: begin
          if (cap_go)       st_q <= ST_CAP;
          else if (drop_go) st_q <= ST_DROP;
        end
        ST_CAP:  if (eot) st_q <= ST_IDLE;
        ST_DROP: if (!vid_active && fifo_empty) st_q <= ST_ARMED;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vcap_gate.sv
module vcap_gate
  import vcap_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              vid_vsync,
  input  logic              vid_active,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              mem_ready,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              cap_busy,
  output logic [NFLAG-1:0]  irq_flags,
  output logic              irq
);
  logic              dec_q, vs_prev_q;
  logic [NFLAG-1:0]  mask_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  size_q;

  // named internal events, visible to the bound checker
  logic act_req, start_err, field_start, eot, dropping;
  logic fifo_push, fifo_pop, fifo_full, fifo_empty, vs_event;
  logic [NFLAG-1:0] set_vec, clr_vec;

  assign act_req  = cfg_wr & (cfg_addr == REG_CTRL) & cfg_wdata[ACT_BIT];
  assign clr_vec  = (cfg_wr && cfg_addr == REG_CLR) ? cfg_wdata[NFLAG-1:0] : '0;
  assign vs_event = vid_vsync & ~vs_prev_q;

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_VS]  = vs_event;
    set_vec[FLG_FS]  = field_start;
    set_vec[FLG_EOT] = eot;
    set_vec[FLG_ERR] = start_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q     <= 1'b0;
      mask_q    <= '0;
      base_q    <= '0;
      size_q    <= '0;
      vs_prev_q <= 1'b0;
    end else begin
      vs_prev_q <= vid_vsync;
      if (cfg_wr) begin
        unique case (cfg_addr)
          REG_CTRL: begin
            dec_q  <= cfg_wdata[DEC_BIT];
            mask_q <= cfg_wdata[MASK_LSB +: NFLAG];
          end
          REG_BASE: base_q <= cfg_wdata[ADDR_W-1:0];
          REG_SIZE: size_q <= cfg_wdata[CNT_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  vcap_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .act_req(act_req), .decimate(dec_q),
    .base_in(base_q), .size_in(size_q), .vid_active(vid_active),
    .pix_valid(pix_valid), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .mem_ready(mem_ready), .busy(cap_busy), .start_err(start_err),
    .field_start(field_start), .eot(eot), .dropping(dropping),
    .push(fifo_push), .pop(fifo_pop), .mem_wr(mem_wr), .mem_addr(mem_addr)
  );

  vcap_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .din(pix_data),
    .pop(fifo_pop), .dout(mem_data), .empty(fifo_empty), .full(fifo_full)
  );

  vcap_irq #(.N(NFLAG)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .mask(mask_q), .flags(irq_flags), .irq(irq)
  );
endmodule

// File: rtl/vcap_gate_chk.sv
module vcap_gate_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vid_active,
  input logic              vid_vsync,
  input logic              mem_ready,
  input logic              mem_wr,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              cap_busy,
  input logic [3:0]        irq_flags,
  input logic              start_err,
  input logic              eot,
  input logic              dropping,
  input logic              fifo_push,
  input logic              fifo_pop,
  input logic              fifo_full
);
  p_accept_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_busy) |-> $past(!vid_active));

  p_err_noarm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_err |=> irq_flags[3] && !$rose(cap_busy));

  p_write_needs_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> cap_busy);

  p_eot_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> irq_flags[2] && !cap_busy);

  p_vsync_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vid_vsync) |=> irq_flags[0]);

  p_drop_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dropping |-> !mem_wr);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> mem_wr && $stable(mem_addr) && $stable(mem_data));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_push && fifo_full && !fifo_pop));
endmodule

bind vcap_gate vcap_gate_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vid_active(vid_active), .vid_vsync(vid_vsync),
  .mem_ready(mem_ready), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_data(mem_data),
  .cap_busy(cap_busy), .irq_flags(irq_flags), .start_err(start_err), .eot(eot),
  .dropping(dropping), .fifo_push(fifo_push), .fifo_pop(fifo_pop), .fifo_full(fifo_full)
);

// File: tb/vcap_gate_test.sv
`timescale 1ns/1ps
module vcap_gate_test;
  localparam int AW = 32, DW = 16;
  localparam logic [31:0] ACT = 32'h0800_0000;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0;
  logic [1:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic vid_vsync = 0, vid_active = 0, pix_valid = 0, mem_ready = 1;
  logic [DW-1:0] pix_data = 0;
  logic mem_wr, cap_busy, irq;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic [3:0] irq_flags;

  int checks = 0, errors = 0;
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];
  int log_n = 0;
  logic stall_en = 0;

  always #4 clk = ~clk;

  vcap_gate uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .vid_vsync(vid_vsync), .vid_active(vid_active), .pix_valid(pix_valid),
    .pix_data(pix_data), .mem_ready(mem_ready), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_data(mem_data), .cap_busy(cap_busy), .irq_flags(irq_flags), .irq(irq)
  );

  always @(negedge clk) begin
    #2;
    if (mem_wr && mem_ready && log_n < 64) begin
      log_addr[log_n] = mem_addr;
      log_data[log_n] = mem_data;
      log_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic vsync_pulse();
    @(negedge clk); vid_vsync = 1;
    repeat (2) @(negedge clk);
    vid_vsync = 0;
    @(negedge clk);
  endtask

  // one field: id tags the data, n words, optional stall of memory
  task automatic field(input int id, input int n);
    @(negedge clk); vid_active = 1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      pix_valid = 1;
      pix_data  = DW'((id << 8) | i);
      mem_ready = !(stall_en && (i == 2 || i == 3));
      @(negedge clk);
    end
    pix_valid = 0; mem_ready = 1;
    repeat (2) @(negedge clk);
    vid_active = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic check_field(input string req, input int id, input logic [31:0] base, input int n);
    chk({req, " word count"}, 32'(log_n), 32'(n));
    for (int i = 0; i < n && i < log_n; i++) begin
      chk({req, " addr"}, log_addr[i], base + 32'(i));
      chk({req, " data"}, 32'(log_data[i]), 32'((id << 8) | i));
    end
  endtask

  task automatic t_reset();
    chk("R7 reset flags", 32'(irq_flags), 0);
    chk("R7 reset irq", 32'(irq), 0);
    chk("R1 reset busy", 32'(cap_busy), 0);
    chk("R4 reset mem_wr", 32'(mem_wr), 0);
  endtask

  task automatic t_flags();
    cfg(2'd0, 32'h0);
    vsync_pulse();
    chk("R6 vsync flag", 32'(irq_flags), 32'h1);
    chk("R7 masked irq", 32'(irq), 0);
    cfg(2'd0, 32'h10);
    chk("R7 enabled irq", 32'(irq), 1);
    cfg(2'd3, 32'h1);
    chk("R7 clear flag", 32'(irq_flags), 0);
    chk("R7 irq after clear", 32'(irq), 0);
    log_n = 0;
    field(1, 4);
    chk("R6 field start flag", 32'(irq_flags[1]), 1);
    chk("R11 no activation no write", 32'(log_n), 0);
    cfg(2'd0, 32'h0);
    cfg(2'd3, 32'hF);
  endtask

  task automatic t_reject();
    cfg(2'd1, 32'h40); cfg(2'd2, 32'd4);
    log_n = 0;
    @(negedge clk); vid_active = 1;
    cfg(2'd0, ACT);
    chk("R2 error flag", 32'(irq_flags[3]), 1);
    chk("R2 not armed", 32'(cap_busy), 0);
    for (int i = 0; i < 4; i++) begin
      pix_valid = 1; pix_data = DW'(i); @(negedge clk);
    end
    pix_valid = 0; vid_active = 0;
    repeat (6) @(negedge clk);
    chk("R2 nothing written", 32'(log_n), 0);
    cfg(2'd3, 32'hF);
  endtask

  task automatic t_capture(input bit stall);
    logic [31:0] base;
    base = stall ? 32'h500 : 32'h100;
    cfg(2'd1, base); cfg(2'd2, 32'd8);
    cfg(2'd0, ACT);
    chk("R1 armed in blanking", 32'(cap_busy), 1);
    cfg(2'd1, 32'h900); cfg(2'd2, 32'd3);
    log_n = 0; stall_en = stall;
    field(stall ? 3 : 2, 10);
    stall_en = 0;
    if (stall) check_field("R10 stalled field", 3, base, 8);
    else       check_field("R3 R4 sampled field", 2, base, 8);
    chk("R5 eot flag", 32'(irq_flags[2]), 1);
    chk("R5 busy cleared", 32'(cap_busy), 0);
    cfg(2'd3, 32'hF);
    log_n = 0;
    field(4, 3);
    chk("R5 needs new activation", 32'(log_n), 0);
  endtask

  task automatic t_decimate();
    cfg(2'd1, 32'h200); cfg(2'd2, 32'd4);
    cfg(2'd0, ACT | 32'h1);
    log_n = 0;
    field(5, 4);
    check_field("R8 first field kept", 5, 32'h200, 4);
    cfg(2'd1, 32'h300);
    cfg(2'd0, ACT | 32'h1);
    log_n = 0;
    field(6, 6);
    chk("R9 dropped field silent", 32'(log_n), 0);
    chk("R9 still armed", 32'(cap_busy), 1);
    field(7, 4);
    check_field("R9 next kept field clean", 7, 32'h300, 4);
    chk("R8 busy after kept", 32'(cap_busy), 0);
    cfg(2'd0, 32'h0);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_flags();
    t_reject();
    t_capture(0);
    t_capture(1);
    t_decimate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule